// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Register

This block watches a running program and records why the system was last reset. A counter advances on each cycle in which the watchdog clock tick is high. When the watchdog is enabled and the counter reaches the end of the selected period, the block drives a one-cycle system reset. Software prevents this by pulsing the restart input before the period ends. The period is one of eight powers of two, picked by a 3-bit select field. The enable bit and the select field are protected. A write carrying the change-enable flag only arms a short window. A second write, made while that window is open, actually changes the settings.

The system reset output is the OR of five sources. The first is power-on, which arrives as a digital level. The second is the external reset pin, and only a low pulse that is long enough counts. The third is brown-out, also a digital level. The fourth is a debug-port reset request. The fifth is the watchdog expiry. Each source has its own sticky flag in a 5-bit cause register. Software reads these flags after boot and clears each one by writing 0 to it. Power-on is the only input that resets the block itself. The other sources raise the system reset but keep the watchdog settings. All control and status pins are plain levels. No data stream passes through the block, so no valid/ready handshake is used.

Top module: `wdt_rst_cause`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1, `cause_o` is 5'b00001, `wdt_en_o` is 0, `wdt_sel_o` is 0 and `chg_open_o` is 0. These values remain after `por_i` falls.
- R2: A write (`cfg_we_i`=1) with `cfg_chg_i`=1 while the window is closed opens the window for `WIN_CYC` (4) cycles and leaves enable and select unchanged. A write made while the window is open loads `cfg_en_i` and `cfg_sel_i` and closes the window.
- R3: A write made while the window is closed and with `cfg_chg_i`=0 changes nothing. A write made `WIN_CYC` or more idle cycles after the window opened changes nothing, because by then the window has closed itself.
- R4: When enabled, the watchdog expires after 2^(BASE_EXP+sel) tick cycles, counted from the clock edge that enabled it or last restarted it. `sys_rst_o` is then high for exactly one cycle, in the cycle after the last counted edge.
- R5: A `kick_i` sampled high clears the count. The next expiry falls a full period after that edge.
- R6: The count advances only on cycles where `tick_i` is high. A disabled watchdog never produces a reset.
- R7: The external pin is synchronised through two flops. It counts as a reset only after it is seen low for at least `MIN_LOW` consecutive cycles. A shorter low pulse leaves `sys_rst_o` and the flag untouched.
- R8: `bor_i` or `dbg_rst_i` high drives `sys_rst_o` high in the same cycle. Each one sets its flag at the next clock edge.
- R9: The bit positions are power-on 0, external 1, brown-out 2, watchdog 3 and debug 4. Flags are sticky. A cause write clears exactly the flags whose written bit is 0. A source that is active in the same cycle wins over the clear.
- R10: Power-on in mid-run clears every other flag, sets only the power-on flag and returns enable and select to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on level, asynchronous reset of the block |
| bor_i | input | 1 | Brown-out level |
| dbg_rst_i | input | 1 | Debug-port reset request |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| tick_i | input | 1 | Watchdog clock tick enable |
| kick_i | input | 1 | Software restart of the count |
| cfg_we_i | input | 1 | Watchdog settings write strobe |
| cfg_chg_i | input | 1 | Change-enable flag of the write |
| cfg_en_i | input | 1 | Enable value of the write |
| cfg_sel_i | input | SEL_W | Period select value of the write |
| cause_we_i | input | 1 | Cause register write strobe |
| cause_wdata_i | input | 5 | Cause write data, 0 clears the flag |
| sys_rst_o | output | 1 | System reset |
| cause_o | output | 5 | Sticky reset-cause flags |
| wdt_en_o | output | 1 | Current enable setting |
| wdt_sel_o | output | SEL_W | Current period select |
| chg_open_o | output | 1 | Change window is open |

## Verification
The bench drives inputs and samples outputs on falling edges, and counts rising edges to know when each result is due. Brown-out and debug requests show on `sys_rst_o` in the cycle they are driven, and their flags show one edge later. A settings write is visible right after its accepting edge. The watchdog reset appears 2^(BASE_EXP+sel) edges after the enabling or restart edge and is checked one edge early (still low), on time (high) and one edge late (low, with its flag now set). A pin low for `MIN_LOW` edges raises the reset two synchroniser edges later. The bench compares a pulse one edge shorter against one of exactly `MIN_LOW` edges.

// File: rtl/wdt_rc_pkg.sv
package wdt_rc_pkg;
  localparam int CAUSE_W = 5;
  localparam int C_POR = 0;
  localparam int C_EXT = 1;
  localparam int C_BOR = 2;
  localparam int C_WDT = 3;
  localparam int C_DBG = 4;
endpackage

// File: rtl/wdt_cfg_guard.sv
// Protected enable/select settings with a self-closing change window.
module wdt_cfg_guard #(
  parameter int SEL_W   = 3,
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             we_i,
  input  logic             chg_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             open_o
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0] win_q;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;

  assign open_o = (win_q != '0);
  assign en_o   = en_q;
  assign sel_o  = sel_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      win_q <= '0;
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (we_i && open_o) begin
      en_q  <= en_i;
      sel_q <= sel_i;
      win_q <= '0;
    end else if (we_i && chg_i) begin
      win_q <= WIN_CYC[WIN_W-1:0];
    end else if (open_o) begin
      win_q <= win_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_period_ctr.sv
// Tick-driven watchdog count with power-of-two period select.
module wdt_period_ctr #(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             kick_i,
  input  logic             hold_i,
  output logic             pulse_o
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             fire;
  logic             pulse_q;

  assign last    = ~({CNT_W{1'b1}} << (BASE_EXP + int'(sel_i)));
  assign fire    = en_i && tick_i && (cnt_q == last);
  assign pulse_o = pulse_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (!en_i || kick_i || hold_i || fire) cnt_q <= '0;
      else if (tick_i)                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pin_qual.sv
// Synchronises the external reset pin and qualifies a minimum low time.
module wdt_pin_qual #(
  parameter int MIN_LOW = 16
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  output logic active_o
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic          s1_q, s2_q;
  logic [LW-1:0] low_q;

  assign active_o = (low_q == MIN_LOW[LW-1:0]);

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      low_q <= '0;
    end else begin
      s1_q <= pin_n_i;
      s2_q <= s1_q;
      if (s2_q)          low_q <= '0;
      else if (!active_o) low_q <= low_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_cause_reg.sv
// Sticky per-source reset flags; write 0 clears, a live source wins.
module wdt_cause_reg #(
  parameter int W = wdt_rc_pkg::CAUSE_W
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic [W-1:0] set_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cause_o
);
  for (genvar b = 0; b < W; b++) begin : g_flag
    localparam logic RST_VAL = (b == wdt_rc_pkg::C_POR);
    logic flag_q;
    always_ff @(posedge clk or posedge por_i) begin
      if (por_i) flag_q <= RST_VAL;
      else       flag_q <= set_i[b] | (flag_q & ~(we_i & ~wdata_i[b]));
    end
    assign cause_o[b] = flag_q;
  end
endmodule

// File: rtl/wdt_rst_cause.sv
module wdt_rst_cause
  import wdt_rc_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3,
  parameter int MIN_LOW  = 16,
  parameter int WIN_CYC  = 4
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic               bor_i,
  input  logic               dbg_rst_i,
  input  logic               ext_rst_n_i,
  input  logic               tick_i,
  input  logic               kick_i,
  input  logic               cfg_we_i,
  input  logic               cfg_chg_i,
  input  logic               cfg_en_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic               cause_we_i,
  input  logic [CAUSE_W-1:0] cause_wdata_i,
  output logic               sys_rst_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               wdt_en_o,
  output logic [SEL_W-1:0]   wdt_sel_o,
  output logic               chg_open_o
);
  logic               ext_active;
  logic               wdt_pulse;
  logic               other_rst;
  logic [CAUSE_W-1:0] cause_set;

  assign other_rst = ext_active | bor_i | dbg_rst_i;
  assign sys_rst_o = por_i | other_rst | wdt_pulse;

  always_comb begin
    cause_set        = '0;
    cause_set[C_EXT] = ext_active;
    cause_set[C_BOR] = bor_i;
    cause_set[C_WDT] = wdt_pulse;
    cause_set[C_DBG] = dbg_rst_i;
  end

  wdt_cfg_guard #(.SEL_W(SEL_W), .WIN_CYC(WIN_CYC)) u_guard (
    .clk(clk), .por_i(por_i), .we_i(cfg_we_i), .chg_i(cfg_chg_i),
    .en_i(cfg_en_i), .sel_i(cfg_sel_i),
    .en_o(wdt_en_o), .sel_o(wdt_sel_o), .open_o(chg_open_o)
  );

  wdt_period_ctr #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_ctr (
    .clk(clk), .por_i(por_i), .tick_i(tick_i), .en_i(wdt_en_o),
    .sel_i(wdt_sel_o), .kick_i(kick_i), .hold_i(other_rst),
    .pulse_o(wdt_pulse)
  );

  wdt_pin_qual #(.MIN_LOW(MIN_LOW)) u_pin (
    .clk(clk), .por_i(por_i), .pin_n_i(ext_rst_n_i), .active_o(ext_active)
  );

  wdt_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk(clk), .por_i(por_i), .set_i(cause_set), .we_i(cause_we_i),
    .wdata_i(cause_wdata_i), .cause_o(cause_o)
  );
endmodule

// File: rtl/wdt_rst_cause_chk.sv
module wdt_rst_cause_chk
  import wdt_rc_pkg::*;
(
  input logic               clk,
  input logic               por_i,
  input logic               bor_i,
  input logic               dbg_rst_i,
  input logic               cfg_we_i,
  input logic               cfg_chg_i,
  input logic               cause_we_i,
  input logic [CAUSE_W-1:0] cause_wdata_i,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               wdt_en_o,
  input logic [2:0]         wdt_sel_o,
  input logic               chg_open_o,
  input logic               wdt_pulse
);
  AST_POR_STATE: assert property (@(posedge clk) disable iff (por_i)
    $fell(por_i) |-> (cause_o == 5'b00001) && !wdt_en_o && (wdt_sel_o == 3'd0)); // R1
  AST_WIN_OPENS: assert property (@(posedge clk) disable iff (por_i)
    (cfg_we_i && cfg_chg_i && !chg_open_o) |=> chg_open_o); // R2
  AST_NO_CFG_CHANGE: assert property (@(posedge clk) disable iff (por_i)
    !(cfg_we_i && chg_open_o) |=> ($stable(wdt_en_o) && $stable(wdt_sel_o))); // R3
  AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (por_i)
    wdt_pulse |=> !wdt_pulse); // R4
  AST_WDT_FLAG: assert property (@(posedge clk) disable iff (por_i)
    wdt_pulse |=> cause_o[C_WDT]); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (por_i)
    !wdt_en_o |=> !wdt_pulse); // R6
  AST_BOR_FLAG: assert property (@(posedge clk) disable iff (por_i)
    bor_i |=> cause_o[C_BOR]); // R8
  AST_DBG_FLAG: assert property (@(posedge clk) disable iff (por_i)
    dbg_rst_i |=> cause_o[C_DBG]); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_i)
    (cause_o[C_WDT] && !(cause_we_i && !cause_wdata_i[C_WDT])) |=> cause_o[C_WDT]); // R9
endmodule

bind wdt_rst_cause wdt_rst_cause_chk u_chk (
  .clk(clk), .por_i(por_i), .bor_i(bor_i), .dbg_rst_i(dbg_rst_i),
  .cfg_we_i(cfg_we_i), .cfg_chg_i(cfg_chg_i), .cause_we_i(cause_we_i),
  .cause_wdata_i(cause_wdata_i), .cause_o(cause_o), .wdt_en_o(wdt_en_o),
  .wdt_sel_o(wdt_sel_o), .chg_open_o(chg_open_o), .wdt_pulse(wdt_pulse)
);

// File: tb/wdt_rst_cause_bench.sv
module wdt_rst_cause_bench;
  localparam int BASE = 6;
  localparam int MINL = 8;
  localparam int P0   = 1 << BASE;

  logic       clk = 1'b0;
  logic       por_i = 1'b1, bor_i = 1'b0, dbg_rst_i = 1'b0, ext_rst_n_i = 1'b1;
  logic       tick_i = 1'b1, kick_i = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_chg_i = 1'b0, cfg_en_i = 1'b0;
  logic [2:0] cfg_sel_i = 3'd0;
  logic       cause_we_i = 1'b0;
  logic [4:0] cause_wdata_i = 5'h1f;
  logic       sys_rst_o, wdt_en_o, chg_open_o;
  logic [4:0] cause_o;
  logic [2:0] wdt_sel_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_rst_cause #(.BASE_EXP(BASE), .SEL_W(3), .MIN_LOW(MINL), .WIN_CYC(4)) u_wdt_rst_cause (
    .clk(clk), .por_i(por_i), .bor_i(bor_i), .dbg_rst_i(dbg_rst_i),
    .ext_rst_n_i(ext_rst_n_i), .tick_i(tick_i), .kick_i(kick_i),
    .cfg_we_i(cfg_we_i), .cfg_chg_i(cfg_chg_i), .cfg_en_i(cfg_en_i),
    .cfg_sel_i(cfg_sel_i), .cause_we_i(cause_we_i), .cause_wdata_i(cause_wdata_i),
    .sys_rst_o(sys_rst_o), .cause_o(cause_o), .wdt_en_o(wdt_en_o),
    .wdt_sel_o(wdt_sel_o), .chg_open_o(chg_open_o)
  );

  typedef struct packed {
    logic [2:0] gap; logic chg; logic en; logic [2:0] sel;
    logic x_en; logic [2:0] x_sel; logic x_open;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd0, 1'b0, 1'b1, 3'd5, 1'b0, 3'd0, 1'b0},  // R3 no chg, closed
    '{3'd0, 1'b1, 1'b1, 3'd5, 1'b0, 3'd0, 1'b1},  // R2 opens only
    '{3'd3, 1'b0, 1'b0, 3'd5, 1'b0, 3'd5, 1'b0},  // R2 last open cycle
    '{3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 1'b1},  // R2 reopen
    '{3'd4, 1'b0, 1'b1, 3'd2, 1'b0, 3'd5, 1'b0},  // R3 window expired
    '{3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 1'b1},  // R2 reopen
    '{3'd0, 1'b1, 1'b1, 3'd2, 1'b1, 3'd2, 1'b0},  // R2 chg write inside window applies
    '{3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0},  // R3 ignored
    '{3'd0, 1'b1, 1'b0, 3'd3, 1'b1, 3'd2, 1'b1},  // R2 reopen
    '{3'd1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0}   // R2 applied, disables
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic chg, input logic en, input logic [2:0] sel, input logic kick);
    cfg_we_i = 1'b1; cfg_chg_i = chg; cfg_en_i = en; cfg_sel_i = sel; kick_i = kick;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_chg_i = 1'b0; kick_i = 1'b0;
  endtask

  task automatic cause_write(input logic [4:0] d);
    cause_we_i = 1'b1; cause_wdata_i = d;
    @(negedge clk);
    cause_we_i = 1'b0; cause_wdata_i = 5'h1f;
  endtask

  task automatic arm(input logic en, input logic [2:0] sel);
    cfg_write(1'b1, 1'b0, 3'd0, 1'b0);
    cfg_write(1'b0, en, sel, 1'b1);
  endtask

  task automatic expect_expiry(input int p, input string req);
    bit early = 0;
    for (int i = 0; i < p - 1; i++) begin
      @(negedge clk);
      early |= sys_rst_o;
    end
    check({req, " no reset before period"}, early, 0);
    @(negedge clk);
    check({req, " reset on period"}, sys_rst_o, 1);
    @(negedge clk);
    check({req, " reset lasts one cycle"}, sys_rst_o, 0);
    check({req, " watchdog flag"}, cause_o[3], 1);
  endtask

  task automatic ext_pulse(input int low_cyc, output bit seen);
    seen = 0;
    ext_rst_n_i = 1'b0;
    for (int i = 0; i < low_cyc; i++) begin
      @(negedge clk);
      seen |= sys_rst_o;
    end
    ext_rst_n_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seen |= sys_rst_o;
    end
  endtask

  initial begin
    bit seen;
    cyc(3);
    // R1 reset state
    check("R1 sys_rst during por", sys_rst_o, 1);
    check("R1 cause during por", cause_o, 5'b00001);
    check("R1 en/sel/open during por", {wdt_en_o, wdt_sel_o, chg_open_o}, 0);
    por_i = 1'b0;
    cyc(2);
    check("R1 state after por", {sys_rst_o, cause_o, wdt_en_o, wdt_sel_o, chg_open_o},
          {1'b0, 5'b00001, 1'b0, 3'd0, 1'b0});

    // R2 / R3 protected writes from the vector table
    for (int v = 0; v < 10; v++) begin
      cyc(int'(VECS[v].gap));
      cfg_write(VECS[v].chg, VECS[v].en, VECS[v].sel, 1'b0);
      check($sformatf("R2/R3 vector %0d en/sel/open", v),
            {wdt_en_o, wdt_sel_o, chg_open_o}, {VECS[v].x_en, VECS[v].x_sel, VECS[v].x_open});
    end

    // R9 clear power-on flag by writing 0
    cause_write(5'b11110);
    check("R9 clear by write 0", cause_o, 5'b00000);

    // R4 expiry at sel 0, then sel 2
    arm(1'b1, 3'd0);
    expect_expiry(P0, "R4 sel0");
    cause_write(5'b10111);
    check("R9 clear watchdog flag", cause_o[3], 0);

    // R5 restart moves the expiry
    cyc(P0 - 10);
    kick_i = 1'b1; @(negedge clk); kick_i = 1'b0;
    expect_expiry(P0, "R5 restart");
    cause_write(5'b10111);

    arm(1'b1, 3'd2);
    expect_expiry(4 * P0, "R4 sel2");
    cause_write(5'b10111);

    // R6 no count without tick, none when disabled
    kick_i = 1'b1; tick_i = 1'b0; @(negedge clk); kick_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 8 * P0; i++) begin @(negedge clk); seen |= sys_rst_o; end
    check("R6 no reset without ticks", seen, 0);
    tick_i = 1'b1;
    arm(1'b0, 3'd0);
    check("R6 disabled", wdt_en_o, 0);
    seen = 0;
    for (int i = 0; i < 3 * P0; i++) begin @(negedge clk); seen |= sys_rst_o; end
    check("R6 disabled never resets", {seen, cause_o[3]}, 0);

    // R7 external pin qualification
    ext_pulse(MINL - 1, seen);
    check("R7 short pulse no reset", {seen, cause_o[1]}, 0);
    ext_pulse(MINL, seen);
    check("R7 long pulse reset", {seen, cause_o[1]}, 2'b11);

    // R8 brown-out and debug
    bor_i = 1'b1; @(negedge clk);
    check("R8 bor reset and flag", {sys_rst_o, cause_o[2]}, 2'b11);
    bor_i = 1'b0;
    dbg_rst_i = 1'b1; @(negedge clk);
    check("R8 dbg reset and flag", {sys_rst_o, cause_o[4]}, 2'b11);
    dbg_rst_i = 1'b0; @(negedge clk);
    check("R8 sources released", sys_rst_o, 0);

    // R9 partial clear, then set beats clear
    cause_write(5'b10011);
    check("R9 partial clear", cause_o, 5'b10010);
    dbg_rst_i = 1'b1;
    cause_write(5'b00000);
    dbg_rst_i = 1'b0;
    check("R9 set wins over clear", cause_o, 5'b10000);

    // R10 power-on in mid-run
    arm(1'b1, 3'd6);
    cause_o_setup: begin bor_i = 1'b1; @(negedge clk); bor_i = 1'b0; end
    check("R10 setup", {wdt_en_o, wdt_sel_o, cause_o}, {1'b1, 3'd6, 5'b10100});
    por_i = 1'b1; @(negedge clk);
    check("R10 por clears flags", cause_o, 5'b00001);
    por_i = 1'b0; @(negedge clk);
    check("R10 por clears settings", {wdt_en_o, wdt_sel_o, sys_rst_o}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule